// File: doc/BRIEF.md
# Floating-Point to Fixed-Point Converter

This unit takes an IEEE 754 half- or single-precision value and converts it to a fixed-point number. The fixed-point number can be signed or unsigned. Its target width is 16 or 32 bits, and it has a programmable number of fraction bits. The fraction count is the target width minus a 5-bit position immediate, so a small immediate places the binary point high in the word.

Every result truncates toward zero. The narrow result is widened to a 32-bit output word: sign extension for signed targets and zero extension for unsigned ones. Three flags come with each result:
- an invalid flag, for NaN, saturation, or a negative value in unsigned mode;
- an inexact flag, set when truncation discarded nonzero bits;
- a bad-configuration flag, set when the immediate is larger than the target width.

Inputs are sampled on a clock edge, and the result and flags appear registered one cycle later.

Top module: `fp2fix_cvt`

## Requirements
- R1: `width_is_32` selects the fixed-point target width: 0 gives 16 bits and 1 gives 32 bits.
- R2: The fraction count F equals the target width minus `pos_imm`, taken as unsigned.
  - When F would be negative (16-bit target with `pos_imm` from 17 to 31), `flag_badcfg` is 1.
  - In that case `fix_out` is 0 and both other flags are 0.
- R3: The result is the source value times 2^F, truncated toward zero. Bits below the lowest fraction bit are dropped.
- R4: When `fix_unsigned` is 0, the result is two's complement and is sign-extended from the target width to 32 bits.
- R5: When `fix_unsigned` is 1, the result is unsigned and is zero-extended to 32 bits.
- R6: When `fmt_is_single` is 0, the operand is the half-precision value in `src_word[15:0]`, and bits 31:16 have no effect. When it is 1, the whole word is a single-precision value.
- R7: A finite value whose truncated result lies outside the target range saturates and sets `flag_invalid`.
  - A positive value saturates to the largest code: 0x7FFF, 0x7FFFFFFF, 0xFFFF or 0xFFFFFFFF.
  - A negative value saturates to the most negative code: 0xFFFF8000 or 0x80000000 for signed targets, 0 for unsigned targets.
- R8: A NaN of either format produces 0 with `flag_invalid` set.
- R9: In unsigned mode, a negative value produces 0. `flag_invalid` is set unless the value truncates to zero; in that case only `flag_inexact` may be set.
- R10: Positive and negative infinity saturate exactly as R7 describes and set `flag_invalid`.
- R11: Subnormal inputs are converted exactly, without flushing to zero.
- R12: `flag_inexact` is 1 exactly when nonzero bits were discarded and `flag_invalid` is 0.
- R13: Result and flags appear one clock after the inputs are sampled. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_word | input | 32 | Floating-point operand |
| fmt_is_single | input | 1 | 1: single precision, 0: half precision in bits 15:0 |
| width_is_32 | input | 1 | 1: 32-bit target, 0: 16-bit target |
| fix_unsigned | input | 1 | 1: unsigned target, 0: signed target |
| pos_imm | input | 5 | Immediate subtracted from the target width to give the fraction count |
| fix_out | output | 32 | Extended fixed-point result |
| flag_invalid | output | 1 | NaN, saturation or invalid negative |
| flag_inexact | output | 1 | Nonzero bits discarded by truncation |
| flag_badcfg | output | 1 | Immediate exceeds the target width |

## Verification
The bench builds the unit with its default parameters:
- a 32-bit output;
- a 16-bit narrow target;
- a 5-bit immediate;
- a 24-bit significand path.

These defaults bring every fraction count from 0 to 32 within reach. They also reach the bad-configuration range at 16-bit width, and the exact left shift of a half-precision subnormal to 256 at F = 32. Single-precision exponents above 2^31 push the shifter into its clamp branch. The expected values come from a real-number model that scales, truncates and compares against the target limits.

// File: rtl/fxc_pkg.sv
package fxc_pkg;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int HP_EXP_W = 5;
    localparam int HP_MAN_W = 10;
    localparam int SIG_W    = SP_MAN_W + 1;
    localparam int SCL_W    = 10;
    localparam int OUT_W    = 32;
    localparam int NARROW_W = 16;
    localparam int IMM_W    = 5;
    localparam int FRAC_W   = $clog2(OUT_W) + 1;
    localparam int MAG_W    = 64;
    localparam int SHIFT_W  = $clog2(SIG_W);

    // value = (-1)^sign * sig * 2^exp
    typedef struct packed {
        logic                    sign;
        logic                    is_nan;
        logic                    is_inf;
        logic signed [SCL_W-1:0] exp;
        logic [SIG_W-1:0]        sig;
    } fxc_op_t;

    typedef struct packed {
        logic [OUT_W-1:0] res;
        logic             invalid;
        logic             inexact;
        logic             bad_cfg;
    } fxc_out_t;
endpackage

// File: rtl/fxc_unpack.sv
module fxc_unpack
    import fxc_pkg::*;
(
    input  logic [OUT_W-1:0] src,
    input  logic             is_single,
    output fxc_op_t          op
);
    localparam int SP_BIAS_LSB = (1 << (SP_EXP_W - 1)) - 1 + SP_MAN_W;
    localparam int HP_PAD      = SP_MAN_W - HP_MAN_W;
    localparam int HP_BIAS_LSB = (1 << (HP_EXP_W - 1)) - 1 + HP_MAN_W + HP_PAD;

    logic [SP_EXP_W-1:0] sp_e;
    logic [SP_MAN_W-1:0] sp_f;
    logic [HP_EXP_W-1:0] hp_e;
    logic [HP_MAN_W-1:0] hp_f;

    assign sp_e = src[SP_MAN_W +: SP_EXP_W];
    assign sp_f = src[SP_MAN_W-1:0];
    assign hp_e = src[HP_MAN_W +: HP_EXP_W];
    assign hp_f = src[HP_MAN_W-1:0];

    always_comb begin
        op = '0;
        if (is_single) begin
            op.sign = src[SP_EXP_W + SP_MAN_W];
            if (&sp_e) begin
                op.is_nan = |sp_f;
                op.is_inf = ~|sp_f;
            end else if (sp_e == '0) begin
                op.sig = {1'b0, sp_f};
                op.exp = SCL_W'(1 - SP_BIAS_LSB);
            end else begin
                op.sig = {1'b1, sp_f};
                op.exp = $signed({{(SCL_W-SP_EXP_W){1'b0}}, sp_e}) - SCL_W'(SP_BIAS_LSB);
            end
        end else begin
            op.sign = src[HP_EXP_W + HP_MAN_W];
            if (&hp_e) begin
                op.is_nan = |hp_f;
                op.is_inf = ~|hp_f;
            end else if (hp_e == '0) begin
                op.sig = {1'b0, hp_f, {HP_PAD{1'b0}}};
                op.exp = SCL_W'(1 - HP_BIAS_LSB);
            end else begin
                op.sig = {1'b1, hp_f, {HP_PAD{1'b0}}};
                op.exp = $signed({{(SCL_W-HP_EXP_W){1'b0}}, hp_e}) - SCL_W'(HP_BIAS_LSB);
            end
        end
    end
endmodule

// File: rtl/fxc_scale.sv
module fxc_scale
    import fxc_pkg::*;
(
    input  fxc_op_t           op,
    input  logic [FRAC_W-1:0] frac,
    input  logic              wide,
    input  logic              uns,
    output logic [OUT_W-1:0]  val,
    output logic              inv,
    output logic              inx
);
    localparam logic signed [SCL_W-1:0] SHL_LIM = SCL_W'(MAG_W - SIG_W);
    localparam logic signed [SCL_W-1:0] SHR_LIM = SCL_W'(-SIG_W);
    localparam logic [MAG_W-1:0]        ONE     = MAG_W'(1);

    logic signed [SCL_W-1:0] sh;
    logic [SHIFT_W-1:0]      rsh;
    logic [SIG_W-1:0]        lowmask;
    logic [FRAC_W-1:0]       tgt;
    logic [MAG_W-1:0]        mag, neg_mag, lim_pos, lim_neg;
    logic                    big, disc, over;

    assign sh  = op.exp + $signed({{(SCL_W-FRAC_W){1'b0}}, frac});
    assign rsh = SHIFT_W'(-sh);
    assign tgt = wide ? FRAC_W'(OUT_W) : FRAC_W'(NARROW_W);

    for (genvar i = 0; i < SIG_W; i++) begin : g_mask
        assign lowmask[i] = (SHIFT_W'(i) < rsh);
    end

    always_comb begin
        big  = 1'b0;
        disc = 1'b0;
        mag  = '0;
        if (sh >= SHL_LIM) begin
            big = |op.sig;
        end else if (sh >= 0) begin
            mag = {{(MAG_W-SIG_W){1'b0}}, op.sig} << sh;
        end else if (sh <= SHR_LIM) begin
            disc = |op.sig;
        end else begin
            mag  = {{(MAG_W-SIG_W){1'b0}}, (op.sig >> rsh)};
            disc = |(op.sig & lowmask);
        end
        neg_mag = -mag;
        lim_pos = uns ? ((ONE << tgt) - ONE) : ((ONE << (tgt - 1'b1)) - ONE);
        lim_neg = uns ? '0 : (ONE << (tgt - 1'b1));
        over    = op.is_inf | big | (op.sign ? (mag > lim_neg) : (mag > lim_pos));

        val = '0;
        inv = 1'b0;
        inx = 1'b0;
        if (op.is_nan) begin
            inv = 1'b1;
        end else if (over) begin
            inv = 1'b1;
            if (op.sign) begin
                val = uns ? '0 : OUT_W'(-lim_neg);
            end else begin
                val = lim_pos[OUT_W-1:0];
            end
        end else begin
            val = op.sign ? neg_mag[OUT_W-1:0] : mag[OUT_W-1:0];
            inx = disc;
        end
    end
endmodule

// File: rtl/fp2fix_cvt.sv
module fp2fix_cvt
    import fxc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] src_word,
    input  logic             fmt_is_single,
    input  logic             width_is_32,
    input  logic             fix_unsigned,
    input  logic [IMM_W-1:0] pos_imm,
    output logic [OUT_W-1:0] fix_out,
    output logic             flag_invalid,
    output logic             flag_inexact,
    output logic             flag_badcfg
);
    fxc_op_t                 op;
    logic signed [FRAC_W:0]  frac_full;
    logic [FRAC_W-1:0]       tgt_w;
    logic [OUT_W-1:0]        sc_val;
    logic                    sc_inv, sc_inx;
    fxc_out_t                st_d, st_q;

    assign tgt_w     = width_is_32 ? FRAC_W'(OUT_W) : FRAC_W'(NARROW_W);
    assign frac_full = $signed({1'b0, tgt_w})
                     - $signed({{(FRAC_W+1-IMM_W){1'b0}}, pos_imm});

    fxc_unpack u_unpack (
        .src       (src_word),
        .is_single (fmt_is_single),
        .op        (op)
    );

    fxc_scale u_scale (
        .op   (op),
        .frac (frac_full[FRAC_W-1:0]),
        .wide (width_is_32),
        .uns  (fix_unsigned),
        .val  (sc_val),
        .inv  (sc_inv),
        .inx  (sc_inx)
    );

    always_comb begin
        st_d = '0;
        if (frac_full[FRAC_W]) begin
            st_d.bad_cfg = 1'b1;
        end else begin
            st_d.res     = sc_val;
            st_d.invalid = sc_inv;
            st_d.inexact = sc_inx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fix_out      = st_q.res;
    assign flag_invalid = st_q.invalid;
    assign flag_inexact = st_q.inexact;
    assign flag_badcfg  = st_q.bad_cfg;
endmodule

// File: rtl/fxc_chk.sv
module fxc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] src,
    input logic        fmt,
    input logic        wide,
    input logic        uns,
    input logic [4:0]  imm,
    input logic [31:0] res,
    input logic        inv,
    input logic        inx,
    input logic        bad
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_bad_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (bad == ($past(!wide) && ($past(imm) > 5'd16))));

    p_bad_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bad |-> (res == 32'h0 && !inv && !inx));

    p_flag_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv && inx));

    p_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(uns) && !$past(wide)) |-> (res[31:16] == {16{res[15]}}));

    p_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(uns) && !$past(wide)) |-> (res[31:16] == 16'h0));

    p_nan_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(fmt) && ($past(src[30:23]) == 8'hFF) && ($past(src[22:0]) != 23'h0) && !bad)
        |-> (res == 32'h0 && inv));

    p_uns_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(uns) && $past(fmt) && $past(src[31])) |-> (res == 32'h0));
endmodule

bind fp2fix_cvt fxc_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .src  (src_word),
    .fmt  (fmt_is_single),
    .wide (width_is_32),
    .uns  (fix_unsigned),
    .imm  (pos_imm),
    .res  (fix_out),
    .inv  (flag_invalid),
    .inx  (flag_inexact),
    .bad  (flag_badcfg)
);

// File: tb/sim_fp2fix_cvt.sv
`timescale 1ns/1ps
module sim_fp2fix_cvt;
    import fxc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_word = '0;
    logic        fmt_is_single = 1'b0;
    logic        width_is_32 = 1'b0;
    logic        fix_unsigned = 1'b0;
    logic [4:0]  pos_imm = '0;
    logic [31:0] fix_out;
    logic        flag_invalid, flag_inexact, flag_badcfg;

    int n_chk = 0;
    int n_fail = 0;
    fxc_out_t exp_q[$];
    string    tag_q[$];

    always #2 clk = ~clk;

    fp2fix_cvt u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_word     (src_word),
        .fmt_is_single(fmt_is_single),
        .width_is_32  (width_is_32),
        .fix_unsigned (fix_unsigned),
        .pos_imm      (pos_imm),
        .fix_out      (fix_out),
        .flag_invalid (flag_invalid),
        .flag_inexact (flag_inexact),
        .flag_badcfg  (flag_badcfg)
    );

    function automatic fxc_out_t model(input logic [31:0] s, input logic fs, input logic ws,
                                       input logic us, input logic [4:0] im);
        fxc_out_t o;
        int  w, f, e, m;
        logic sgn, nan, inf;
        real v, sc, a, mr, tr, hi, lo;
        o = '0;
        w = ws ? 32 : 16;
        f = w - int'(im);
        if (f < 0) begin
            o.bad_cfg = 1'b1;
            return o;
        end
        if (fs) begin
            sgn = s[31]; e = int'(s[30:23]); m = int'(s[22:0]);
            nan = (e == 255) && (m != 0);
            inf = (e == 255) && (m == 0);
            v = (e == 0) ? real'(m) * 2.0**(-149) : real'(m + 8388608) * 2.0**(e - 150);
        end else begin
            sgn = s[15]; e = int'(s[14:10]); m = int'(s[9:0]);
            nan = (e == 31) && (m != 0);
            inf = (e == 31) && (m == 0);
            v = (e == 0) ? real'(m) * 2.0**(-24) : real'(m + 1024) * 2.0**(e - 25);
        end
        hi = us ? (2.0**w - 1.0) : (2.0**(w-1) - 1.0);
        lo = us ? 0.0 : -(2.0**(w-1));
        if (nan) begin
            o.invalid = 1'b1;
            return o;
        end
        if (inf) begin
            o.invalid = 1'b1;
            o.res = sgn ? 32'(longint'(lo)) : 32'(longint'(hi));
            return o;
        end
        sc = v * 2.0**f;
        a  = sc;
        mr = $floor(a);
        tr = sgn ? -mr : mr;
        if (tr > hi) begin
            o.invalid = 1'b1; o.res = 32'(longint'(hi));
        end else if (tr < lo) begin
            o.invalid = 1'b1; o.res = 32'(longint'(lo));
        end else begin
            o.res = 32'(longint'(tr));
            o.inexact = (mr != a);
        end
        return o;
    endfunction

    task automatic drv(input logic [31:0] s, input logic fs, input logic ws,
                       input logic us, input logic [4:0] im, input string tag);
        @(negedge clk);
        src_word = s; fmt_is_single = fs; width_is_32 = ws; fix_unsigned = us; pos_imm = im;
        exp_q.push_back(model(s, fs, ws, us, im));
        tag_q.push_back(tag);
    endtask

    // monitor: result registered on the edge after the drive
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                fxc_out_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if ({fix_out, flag_invalid, flag_inexact, flag_badcfg} != e) begin
                    n_fail++;
                    $display("FAIL %s: got res=%h inv=%b inx=%b bad=%b, expected res=%h inv=%b inx=%b bad=%b",
                             t, fix_out, flag_invalid, flag_inexact, flag_badcfg,
                             e.res, e.invalid, e.inexact, e.bad_cfg);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got no completion, expected end of stimulus");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if ({fix_out, flag_invalid, flag_inexact, flag_badcfg} != 35'h0) begin
            n_fail++;
            $display("FAIL R13 reset: got %h, expected 0", {fix_out, flag_invalid, flag_inexact, flag_badcfg});
        end
        @(negedge clk);
        rst_n = 1'b1;

        drv(32'h3F80_0000, 1, 0, 0, 5'd16, "R1 R13 1.0 w16 F0");
        drv(32'h3F80_0000, 1, 1, 0, 5'd16, "R1 1.0 w32 F16");
        drv(32'h3FC0_0000, 1, 1, 0, 5'd31, "R2 1.5 F1");
        drv(32'h3FC0_0000, 1, 0, 0, 5'd17, "R2 bad config");
        drv(32'h3FC0_0000, 1, 0, 1, 5'd31, "R2 bad config imm31");
        drv(32'h3FC0_0000, 1, 1, 0, 5'd0,  "R2 F32 overflow");
        drv(32'h3E80_0000, 1, 1, 1, 5'd0,  "R2 0.25 F32");
        drv(32'h4030_0000, 1, 0, 0, 5'd16, "R3 2.75 trunc");
        drv(32'hC030_0000, 1, 0, 0, 5'd16, "R3 R4 -2.75 trunc");
        drv(32'hC030_0000, 1, 0, 0, 5'd15, "R4 -2.75 F1");
        drv(32'hC700_0000, 1, 0, 0, 5'd16, "R4 -32768 exact");
        drv(32'h4030_0000, 1, 0, 1, 5'd8,  "R5 2.75 uns F8");
        drv(32'h477F_FF00, 1, 0, 1, 5'd16, "R5 65535");
        drv(32'hDEAD_3C00, 0, 1, 0, 5'd16, "R6 half upper ignored");
        drv(32'h0000_C100, 0, 0, 0, 5'd16, "R6 half -2.5");
        drv(32'h46FF_FE00, 1, 0, 0, 5'd16, "R7 32767 fits");
        drv(32'h4700_0000, 1, 0, 0, 5'd16, "R7 32768 sat");
        drv(32'hC700_0200, 1, 0, 0, 5'd16, "R7 -32770 sat");
        drv(32'h4F00_0000, 1, 1, 0, 5'd0,  "R7 2^31 sat");
        drv(32'hCF00_0000, 1, 1, 0, 5'd0,  "R7 -2^31 exact");
        drv(32'h5015_02F9, 1, 1, 1, 5'd0,  "R7 1e10 uns sat");
        drv(32'hD015_02F9, 1, 1, 0, 5'd0,  "R7 -1e10 sat");
        drv(32'h7FC0_0000, 1, 1, 0, 5'd16, "R8 nan single");
        drv(32'h0000_7E00, 0, 0, 1, 5'd16, "R8 nan half");
        drv(32'hBFC0_0000, 1, 1, 1, 5'd0,  "R9 -1.5 uns");
        drv(32'hBF00_0000, 1, 1, 1, 5'd0,  "R9 -0.5 uns");
        drv(32'h8000_0000, 1, 1, 1, 5'd0,  "R9 -0 uns");
        drv(32'h7F80_0000, 1, 0, 0, 5'd16, "R10 +inf");
        drv(32'hFF80_0000, 1, 1, 0, 5'd0,  "R10 -inf");
        drv(32'h0000_FC00, 0, 0, 1, 5'd16, "R10 -inf half uns");
        drv(32'h0000_0001, 0, 1, 0, 5'd0,  "R11 half subnormal");
        drv(32'h0000_83FF, 0, 1, 0, 5'd0,  "R11 neg half subnormal");
        drv(32'h0040_0000, 1, 1, 0, 5'd0,  "R11 single subnormal");
        drv(32'h0000_3555, 0, 1, 0, 5'd0,  "R12 half third");
        drv(32'h3F00_0000, 1, 0, 0, 5'd16, "R12 0.5 F0");
        drv(32'h42C8_0000, 1, 1, 0, 5'd16, "R12 100 exact");

        for (int i = 0; i < 300; i++) begin
            logic [31:0] s;
            s = $urandom;
            if (i % 2 == 0) s[30:23] = 8'(110 + ($urandom % 50));
            drv(s, 1'($urandom), 1'($urandom), 1'($urandom), 5'($urandom), "R3 random");
        end

        repeat (4) @(posedge clk);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule